// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from five peripheral sources for a small 8-bit CPU and decides when, and which one, the CPU should service. Each source has a pending flag and an enable bit. A single master enable gates all servicing. Peripherals raise one-cycle request pulses. The CPU reaches the enable and flag registers through a simple register port, and it sets or clears the master enable through two command inputs.

When the master enable is set and at least one source is both pending and enabled, the controller picks the highest-numbered such source. In the same clock step it clears that source's flag and the master enable. One cycle later it presents a single-cycle take strobe together with the 16-bit service address for that source. Pushing the return address and jumping are left to the CPU.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The enable and flag registers each hold five bits, in positions 4:0. On a read, bits 7:5 are always zero, and write data bits 7:5 are discarded.
- R2: Address 0xFF0F selects the flag register and address 0xFFFF selects the enable register. A read of any other address returns 0x00, and a write to any other address changes neither register.
- R3: A source is serviced only when the master enable is 1 and the AND of the enable and flag registers is nonzero. Pending flags with the master enable at 0, or with their enable bits at 0, produce no take strobe.
- R4: When several enabled sources are pending, the highest bit index wins. Bit 4 has the highest priority and bit 0 the lowest.
- R5: The service address for the source in bit n is 0x0040 + 8*n, which gives 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060.
- R6: On the clock edge where a source is picked, its flag bit and the master enable are both cleared. The take strobe rises on that edge and is seen in the following cycle.
- R7: The take strobe lasts exactly one cycle. No further source is serviced until the master enable is set again.
- R8: A one-cycle pulse on request input n sets flag bit n on the next edge. Bit 0 is the vertical-blank source and bit 4 is the joypad source.
- R9: If a request pulse and a CPU write to the flag register fall in the same cycle, the requested bit ends up set, whatever the write data holds for that bit.
- R10: The enable-interrupts command sets the master enable on the next edge, and the disable-interrupts command clears it. If both commands arrive in the same cycle, disable wins. Servicing in the same cycle as an enable command also leaves the master enable cleared.
- R11: Reset clears the enable register, the flag register, the master enable and the take strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 16 | CPU register address |
| reg_wr | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data for reg_addr (combinational) |
| req_i | input | 5 | Per-source request pulses; bit n sets flag n |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| ime_o | output | 1 | Current master enable |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vector_o | output | 16 | Service address that goes with take_o |

## Verification
If a flag or enable bit is corrupted, it shows up at once in a register read. It also shows up one cycle after the master enable is set, as a wrong, missing or extra take strobe. A wrong priority order or vector computation appears in the very first cycle that take_o is high, as a wrong vector_o value. If the master enable is not dropped on service, take_o stays high for a second cycle, which the pulse-width checks catch immediately.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int          NUM_SRC    = 5;
  localparam int          DATA_W     = 8;
  localparam int          ADDR_W     = 16;
  localparam int          VEC_W      = 16;
  localparam logic [15:0] ADDR_ENA   = 16'hFFFF;
  localparam logic [15:0] ADDR_FLG   = 16'hFF0F;
  localparam logic [15:0] VEC_BASE   = 16'h0040;
  localparam int          VEC_STRIDE = 8;
  localparam int          IDX_W      = $clog2(NUM_SRC);

  typedef logic [NUM_SRC-1:0] src_mask_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = irqc_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ena,
  input  logic         wr_flg,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] req,
  input  logic [N-1:0] svc_clr,
  output logic [N-1:0] ena_q,
  output logic [N-1:0] flg_q
);
  logic [N-1:0] ena_d;
  logic [N-1:0] flg_d;

  // Flag next state: CPU write first, then service clear, then requests on top.
  always_comb begin
    ena_d = wr_ena ? wdata : ena_q;
    flg_d = wr_flg ? wdata : flg_q;
    flg_d = flg_d & ~svc_clr;
    flg_d = flg_d | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      flg_q <= '0;
    end else begin
      ena_q <= ena_d;
      flg_q <= flg_d;
    end
  end

  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> ((flg_q & $past(req)) == $past(req))) else $error("req lost"); // R8
  AST_REQ_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && (|req)) |=> ((flg_q & $past(req)) == $past(req))) else $error("write beat req"); // R9
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int          N      = irqc_pkg::NUM_SRC,
  parameter int          IDX_W  = irqc_pkg::IDX_W,
  parameter int          VEC_W  = irqc_pkg::VEC_W,
  parameter logic [15:0] BASE   = irqc_pkg::VEC_BASE,
  parameter int          STRIDE = irqc_pkg::VEC_STRIDE
) (
  input  logic [N-1:0]     pend,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [VEC_W-1:0] vector
);
  logic [IDX_W-1:0] idx;

  // Highest index wins: a bit is granted only if no higher bit is pending.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      if (g == N - 1) begin : g_top
        assign grant[g] = pend[g];
      end else begin : g_low
        assign grant[g] = pend[g] & ~(|pend[N-1:g+1]);
      end
    end
  endgenerate

  assign any = |pend;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

  assign vector = VEC_W'(BASE) + VEC_W'(idx) * VEC_W'(STRIDE);
endmodule

// File: rtl/irqc_master.sv
module irqc_master #(
  parameter int VEC_W = irqc_pkg::VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             any_pend,
  input  logic [VEC_W-1:0] vec_in,
  output logic             take_now,
  output logic             ime_q,
  output logic             take_q,
  output logic [VEC_W-1:0] vec_q
);
  logic ime_d;
  logic take_d;

  assign take_now = ime_q & any_pend;

  always_comb begin
    take_d = take_now;
    if (take_now)    ime_d = 1'b0;
    else if (di_cmd) ime_d = 1'b0;
    else if (ei_cmd) ime_d = 1'b1;
    else             ime_d = ime_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      ime_q  <= ime_d;
      take_q <= take_d;
      if (take_now) vec_q <= vec_in;
    end
  end

  AST_TAKE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_q) |-> $past(ime_q)) else $error("take without ime"); // R3
  AST_SVC_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> !ime_q) else $error("ime kept on service"); // R6
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q) else $error("take longer than a cycle"); // R7
  AST_DI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    di_cmd |=> !ime_q) else $error("di ignored"); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  output logic              ime_o,
  output logic              take_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic      rst_sync_n;
  logic      sel_ena;
  logic      sel_flg;
  src_mask_t ena_q;
  src_mask_t flg_q;
  src_mask_t pend;
  src_mask_t grant;
  src_mask_t svc_clr;
  logic      any_pend;
  logic      take_now;
  logic [VEC_W-1:0] arb_vec;
  logic      unused_wdata_hi;

  assign unused_wdata_hi = &{1'b0, reg_wdata[DATA_W-1:NUM_SRC]};

  irqc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign sel_ena = (reg_addr == ADDR_ENA);
  assign sel_flg = (reg_addr == ADDR_FLG);

  irqc_flag_bank #(.N(NUM_SRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ena  (reg_wr & sel_ena),
    .wr_flg  (reg_wr & sel_flg),
    .wdata   (reg_wdata[NUM_SRC-1:0]),
    .req     (req_i),
    .svc_clr (svc_clr),
    .ena_q   (ena_q),
    .flg_q   (flg_q)
  );

  assign pend = ena_q & flg_q;

  irqc_arbiter #(.N(NUM_SRC)) u_arb (
    .pend   (pend),
    .grant  (grant),
    .any    (any_pend),
    .vector (arb_vec)
  );

  irqc_master #(.VEC_W(VEC_W)) u_master (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ei_cmd   (ei_cmd),
    .di_cmd   (di_cmd),
    .any_pend (any_pend),
    .vec_in   (arb_vec),
    .take_now (take_now),
    .ime_q    (ime_o),
    .take_q   (take_o),
    .vec_q    (vector_o)
  );

  assign svc_clr = take_now ? grant : '0;

  always_comb begin
    reg_rdata = '0;
    if (sel_ena)      reg_rdata[NUM_SRC-1:0] = ena_q;
    else if (sel_flg) reg_rdata[NUM_SRC-1:0] = flg_q;
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[DATA_W-1:NUM_SRC] == '0) else $error("upper bits set"); // R1
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant)) else $error("multiple grants"); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_o |-> (vector_o >= 16'h0040 && vector_o <= 16'h0060 && vector_o[2:0] == 3'b000))
    else $error("vector out of range"); // R5
  AST_SVC_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take_now && !(|(req_i & grant))) |=> ((flg_q & $past(grant)) == '0))
    else $error("serviced flag kept"); // R6
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [4:0]  req_i;
  logic        ei_cmd;
  logic        di_cmd;
  logic        ime_o;
  logic        take_o;
  logic [15:0] vector_o;

  int checks;
  int failures;
  int takes;
  logic [15:0] last_vec;
  logic        prev_take;
  int          long_pulses;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_i(req_i),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .ime_o(ime_o), .take_o(take_o),
    .vector_o(vector_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Take monitor, sampled 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (rst_n && take_o) begin
      takes++;
      last_vec = vector_o;
      if (prev_take) long_pulses++;
    end
    prev_take = rst_n && take_o;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [15:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 16'h0000; reg_wdata = 8'h00;
  endtask

  task automatic reg_read(logic [15:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 16'h0000;
  endtask

  task automatic pulse_req(logic [4:0] m);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic do_ei();
    ei_cmd = 1'b1;
    @(negedge clk);
    ei_cmd = 1'b0;
  endtask

  task automatic do_di();
    di_cmd = 1'b1;
    @(negedge clk);
    di_cmd = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_write(16'hFFFF, 8'h1F);
    reg_write(16'hFF0F, 8'h1F);
    rst_n = 1'b0;
    #2;
    reg_read(16'hFFFF, d); check("R11 enable after reset", d, 8'h00);
    reg_read(16'hFF0F, d); check("R11 flags after reset", d, 8'h00);
    check("R11 ime after reset", ime_o, 1'b0);
    check("R11 take after reset", take_o, 1'b0);
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_write(16'hFFFF, 8'hFF);
    reg_read(16'hFFFF, d); check("R1 enable upper bits", d, 8'h1F);
    reg_write(16'hFF0F, 8'hE3);
    reg_read(16'hFF0F, d); check("R1 flag upper bits", d, 8'h03);
    reg_write(16'hFF80, 8'h00);
    reg_read(16'hFFFF, d); check("R2 stray write enable", d, 8'h1F);
    reg_read(16'hFF0F, d); check("R2 stray write flags", d, 8'h03);
    reg_read(16'hFF80, d); check("R2 stray read", d, 8'h00);
    cyc(4);
    check("R3 no take with ime clear", takes, 0);
    reg_write(16'hFFFF, 8'h00);
    reg_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_vblank();
    logic [7:0] d;
    int t0;
    t0 = takes;
    reg_write(16'hFFFF, 8'h01);
    pulse_req(5'b00001);
    reg_read(16'hFF0F, d); check("R8 vblank sets bit0", d, 8'h01);
    do_ei();
    cyc(4);
    check("R6 one take", takes - t0, 1);
    check("R5 vblank vector", last_vec, 16'h0040);
    reg_read(16'hFF0F, d); check("R6 flag cleared", d, 8'h00);
    check("R6 ime cleared", ime_o, 1'b0);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    int t0;
    t0 = takes;
    reg_write(16'hFFFF, 8'h1F);
    pulse_req(5'b10001);
    reg_read(16'hFF0F, d); check("R8 joypad sets bit4", d, 8'h11);
    do_ei();
    cyc(6);
    check("R4 joypad first", last_vec, 16'h0060);
    check("R7 single take until ei", takes - t0, 1);
    reg_read(16'hFF0F, d); check("R6 only bit4 cleared", d, 8'h01);
    do_ei();
    cyc(4);
    check("R7 second take after ei", takes - t0, 2);
    check("R4 then vblank", last_vec, 16'h0040);
  endtask

  task automatic t_masked();
    int t0;
    t0 = takes;
    reg_write(16'hFFFF, 8'h04);
    reg_write(16'hFF0F, 8'h1B);
    do_ei();
    cyc(4);
    check("R3 masked no take", takes - t0, 0);
    check("R3 ime stays set", ime_o, 1'b1);
    pulse_req(5'b00100);
    cyc(3);
    check("R3 enabled source taken", takes - t0, 1);
    check("R5 bit2 vector", last_vec, 16'h0050);
    reg_write(16'hFF0F, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    reg_write(16'hFFFF, 8'h00);
    req_i = 5'b01000;
    reg_write(16'hFF0F, 8'h00);
    req_i = '0;
    reg_read(16'hFF0F, d); check("R9 request beats write", d, 8'h08);
  endtask

  task automatic t_cmds();
    int t0;
    t0 = takes;
    do_ei();
    check("R10 ei sets ime", ime_o, 1'b1);
    do_di();
    check("R10 di clears ime", ime_o, 1'b0);
    ei_cmd = 1'b1; di_cmd = 1'b1;
    @(negedge clk);
    ei_cmd = 1'b0; di_cmd = 1'b0;
    check("R10 di wins over ei", ime_o, 1'b0);
    reg_write(16'hFFFF, 8'h08);
    cyc(3);
    check("R10 no take with ime clear", takes - t0, 0);
    do_ei();
    cyc(4);
    check("R10 take after ei", takes - t0, 1);
    check("R5 bit3 vector", last_vec, 16'h0058);
  endtask

  task automatic t_all_vectors();
    logic [7:0] d;
    for (int n = 0; n < 5; n++) begin
      int t0;
      t0 = takes;
      reg_write(16'hFFFF, 8'(1 << n));
      pulse_req(5'(1 << n));
      do_ei();
      cyc(4);
      check("R5 take per source", takes - t0, 1);
      check("R5 vector per source", last_vec, 32'h40 + 32'(8 * n));
      reg_read(16'hFF0F, d); check("R6 flag cleared per source", d, 8'h00);
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; takes = 0; long_pulses = 0;
    last_vec = '0; prev_take = 1'b0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; req_i = '0;
    ei_cmd = 1'b0; di_cmd = 1'b0;
    rst_n = 1'b0;
    cyc(1);
    apply_reset();
    t_reset();
    t_regs();
    t_vblank();
    t_priority();
    t_masked();
    t_collision();
    t_cmds();
    t_all_vectors();
    cyc(2);
    check("R7 take pulses one cycle wide", long_pulses, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule